// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a memory-mapped serial peripheral interface master. A host writes and reads a small set of 32-bit registers over a simple bus made of an address, a write strobe, a read strobe, write data and combinational read data. The controller drives the serial clock and the outbound data line, samples the inbound data line, and raises an interrupt once enough received words have collected. Chip selects are not generated here; the system drives them from general-purpose pins.

The controller runs in one of two operating modes. In configuration mode the control registers accept writes and the shifter stays parked. In active mode the control registers are frozen, and the shifter sends words on its own whenever the transmit queue holds one. Words are 8 or 16 bits long and are shifted most-significant or least-significant bit first. Clock polarity and phase cover the four usual SPI modes. The serial clock period is a programmable multiple of the base clock. A four-entry transmit queue and a four-entry receive queue sit between the bus and the shifter. Every word sent brings back exactly one received word.

Register map (byte offsets): 0x00 mode control, 0x04 format control, 0x08 rate and length control, 0x14 status, 0x18 data.

Top module: `spim_top`

## Requirements
- R1: After reset, mode control reads 0x40 (configuration mode, stop clear), format control reads 0x0004 (MSB first, mode 0, level 1, interrupt disabled), rate control reads 0x0108 (divider 1, 8-bit words), status reads 0x0004 (idle, both queues empty), the interrupt is low and the serial clock sits at 0.
- R2: Mode control bits 7:6 hold the operating mode, with 01 meaning configuration and 10 meaning active, and they read back as written. Writes to format control and rate control change those registers only while the mode is 01; at any other time they are ignored.
- R3: The serial clock idles at format bit 0 (polarity). Format bit 1 (phase) picks the sampling edge: with phase equal to polarity the receiver samples on the rising clock edge, otherwise on the falling edge. Each data bit is valid on the outbound line at its sampling edge. Format bit 2 set sends bit len-1 first; cleared sends bit 0 first.
- R4: Each transmitted word captures exactly one received word, with the inbound bits placed in the same bit order as the outbound ones. Reading the data register returns the oldest received word and removes it from the receive queue.
- R5: Rate control bits 15:8 hold the divider n, and one serial clock period lasts n+1 base clock cycles. A divider of 0 behaves as 1.
- R6: Writing the data register pushes bits 15:0 into the four-entry transmit queue; a write to a full queue is dropped. Status bits 13:11 give the transmit queue count and bits 10:8 the receive queue count.
- R7: Format bits 13:12 hold the receive level minus one, and format bit 9 enables the interrupt. Status bit 14 is set while the receive count is at least the level, and the interrupt output equals status bit 14 ANDed with the enable bit, so it drops as soon as reads take the count below the level.
- R8: Status bit 2 is set exactly when the transmit queue is empty and no word is being shifted.
- R9: The shifter starts a word only in active mode with mode control bit 1 (stop) clear; while stop is set, queued words stay queued.
- R10: Writing mode control with bit 0 set empties both queues at once.
- R11: Rate control bits 7:0 set the word length: the value 16 selects 16-bit words and any other value selects 8-bit words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a read of the data register pops a word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| irq | output | 1 | Receive-level interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Outbound serial data |
| miso | input | 1 | Inbound serial data |

## Verification
A register write is visible on the next edge, so the bench reads back after a full cycle. The shifter starts one cycle after the active-mode write lands, which is why the idle bit is checked low three cycles later, well inside the shortest word of 16 base cycles. The last received word is pushed on the same edge that ends the shifting, so status, interrupt and idle are all checked together once the interrupt is seen. The interrupt drop is checked one cycle after the popping read. The serial clock period is measured as the time between the first two sampling edges, which must be (n+1) times 4 ns. A bench slave model records the outbound bits on the sampling edge and moves the inbound bit just after it, independent of the mode.

// File: rtl/spim_pkg.sv
// Shared definitions for the SPI master: operating modes, register
// offsets and the format-control field layout.
package spim_pkg;

    typedef enum logic [1:0] {
        OPM_OFF = 2'b00,
        OPM_CFG = 2'b01,
        OPM_RUN = 2'b10,
        OPM_RSV = 2'b11
    } opmode_e;

    localparam logic [7:0] REG_MCTL = 8'h00;
    localparam logic [7:0] REG_FMT  = 8'h04;
    localparam logic [7:0] REG_RATE = 8'h08;
    localparam logic [7:0] REG_STAT = 8'h14;
    localparam logic [7:0] REG_DATA = 8'h18;

    // Format control fields, kept packed so the checker can watch them as a vector
    typedef struct packed {
        logic [1:0] lvl;
        logic       rxie;
        logic       msb;
        logic       cpha;
        logic       cpol;
    } fmt_t;

endpackage

// File: rtl/spim_fifo.sv
// Synchronous word queue with an occupancy count.
// Assumes: a push to a full queue and a pop from an empty one are dropped;
// flush empties the queue and overrides push and pop in the same cycle.
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             push_ok;
    logic             pop_ok;

    assign push_ok = push && (cnt_q != CNT_W'(DEPTH)) && !flush;
    assign pop_ok  = pop && (cnt_q != '0) && !flush;
    assign rdata   = mem[rd_ptr];
    assign count   = cnt_q;

    // Storage write, no reset needed on the data array
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and count upkeep
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

endmodule

// File: rtl/spim_shifter.sv
// Serial engine: shifts one word out on mosi while capturing one word from miso.
// Assumes: div >= 1 after the zero-to-one substitution; each bit spans div+1
// base cycles, the serial clock toggles at the middle count and at the bit end,
// and miso is captured on the base edge that creates the middle toggle, which
// is the sampling edge in all four clock modes. Length, order and divider are
// latched when a word starts; polarity and phase are used live.
module spim_shifter #(
    parameter int WORD_MAX = 16,
    parameter int DIV_W    = 8,
    localparam int BIT_W   = $clog2(WORD_MAX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [WORD_MAX-1:0] tx_word,
    input  logic                wide,
    input  logic                msb,
    input  logic                cpol,
    input  logic                cpha,
    input  logic [DIV_W-1:0]    div,
    input  logic                miso,
    output logic                busy,
    output logic                done,
    output logic [WORD_MAX-1:0] rx_word,
    output logic                sclk,
    output logic                mosi
);

    logic                busy_q;
    logic [DIV_W-1:0]    cnt_q;
    logic [BIT_W-1:0]    bit_q;
    logic [WORD_MAX-1:0] txw_q;
    logic [WORD_MAX-1:0] rxw_q;
    logic [DIV_W-1:0]    div_q;
    logic                wide_q;
    logic                msb_q;

    logic [BIT_W-1:0]    last_bit;
    logic [BIT_W-1:0]    idx;
    logic [DIV_W:0]      half_w;
    logic [DIV_W:0]      cnt_x;
    logic                second_half;
    logic                sample;
    logic                bit_end;
    logic [DIV_W-1:0]    div_eff;

    // Bit timing and bit selection derived from the latched word settings
    always_comb begin
        last_bit    = wide_q ? BIT_W'(WORD_MAX - 1) : BIT_W'(WORD_MAX / 2 - 1);
        idx         = msb_q ? (last_bit - bit_q) : bit_q;
        half_w      = ({1'b0, div_q} + (DIV_W + 1)'(1)) >> 1;
        cnt_x       = {1'b0, cnt_q};
        second_half = (cnt_x >= half_w);
        sample      = busy_q && (cnt_x == (half_w - (DIV_W + 1)'(1)));
        bit_end     = (cnt_q == div_q);
        div_eff     = (div == '0) ? DIV_W'(1) : div;
    end

    assign busy    = busy_q;
    assign done    = busy_q && bit_end && (bit_q == last_bit);
    assign rx_word = rxw_q;
    assign sclk    = cpol ^ (busy_q & (second_half ^ cpha));
    assign mosi    = busy_q & txw_q[idx];

    // Word sequencing: load on start, capture mid-bit, advance at bit end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            bit_q  <= '0;
            txw_q  <= '0;
            rxw_q  <= '0;
            div_q  <= DIV_W'(1);
            wide_q <= 1'b0;
            msb_q  <= 1'b1;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                bit_q  <= '0;
                txw_q  <= tx_word;
                rxw_q  <= '0;
                div_q  <= div_eff;
                wide_q <= wide;
                msb_q  <= msb;
            end
        end else begin
            if (sample) begin
                rxw_q[idx] <= miso;
            end
            if (bit_end) begin
                cnt_q <= '0;
                bit_q <= bit_q + 1'b1;
                if (bit_q == last_bit) begin
                    busy_q <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spim_regs.sv
// Register file and bus decode for the SPI master.
// Assumes: DIV_W is 8 so the divider fits rate bits 15:8; queue counts fit
// three status bits; write data bits above 15 carry nothing.
module spim_regs
    import spim_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int DIV_W    = 8,
    parameter int CNT_W    = 3,
    parameter int WORD_MAX = 16,
    localparam int LEN_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [CNT_W-1:0]    tx_cnt,
    input  logic [CNT_W-1:0]    rx_cnt,
    input  logic                busy,
    input  logic [WORD_MAX-1:0] rx_head,
    output opmode_e             mode,
    output logic                run_en,
    output fmt_t                fmt,
    output logic [DIV_W-1:0]    div,
    output logic [LEN_W-1:0]    len,
    output logic                wide,
    output logic                tx_push,
    output logic                rx_pop,
    output logic                fifo_clr,
    output logic                irq,
    output logic                rx_hit,
    output logic                idle
);

    opmode_e          mode_q;
    logic             stop_q;
    fmt_t             fmt_q;
    logic [DIV_W-1:0] div_q;
    logic [LEN_W-1:0] len_q;

    logic hit_mctl, hit_fmt, hit_rate, hit_stat, hit_data;
    logic [CNT_W:0]  need_w;
    logic [DATA_W-1:0] stat_w;
    logic wdata_unused;

    assign hit_mctl = (bus_addr == ADDR_W'(REG_MCTL));
    assign hit_fmt  = (bus_addr == ADDR_W'(REG_FMT));
    assign hit_rate = (bus_addr == ADDR_W'(REG_RATE));
    assign hit_stat = (bus_addr == ADDR_W'(REG_STAT));
    assign hit_data = (bus_addr == ADDR_W'(REG_DATA));
    assign wdata_unused = ^bus_wdata[DATA_W-1:16];

    // Mode control: operating mode and stop request, writable at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= OPM_CFG;
            stop_q <= 1'b0;
        end else if (bus_we && hit_mctl) begin
            mode_q <= opmode_e'(bus_wdata[7:6]);
            stop_q <= bus_wdata[1];
        end
    end

    // Format and rate control: accepted only in configuration mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q <= '{lvl: 2'd0, rxie: 1'b0, msb: 1'b1, cpha: 1'b0, cpol: 1'b0};
            div_q <= DIV_W'(1);
            len_q <= LEN_W'(8);
        end else if (bus_we && (mode_q == OPM_CFG)) begin
            if (hit_fmt) begin
                fmt_q <= '{lvl: bus_wdata[13:12], rxie: bus_wdata[9],
                           msb: bus_wdata[2], cpha: bus_wdata[1], cpol: bus_wdata[0]};
            end
            if (hit_rate) begin
                div_q <= bus_wdata[8 +: DIV_W];
                len_q <= bus_wdata[LEN_W-1:0];
            end
        end
    end

    // Queue strobes, level compare, interrupt and idle flag
    always_comb begin
        tx_push  = bus_we && hit_data;
        rx_pop   = bus_rd && hit_data;
        fifo_clr = bus_we && hit_mctl && bus_wdata[0];
        need_w   = (CNT_W + 1)'(fmt_q.lvl) + (CNT_W + 1)'(1);
        rx_hit   = ({1'b0, rx_cnt} >= need_w);
        irq      = rx_hit && fmt_q.rxie;
        idle     = (tx_cnt == '0) && !busy;
    end

    // Status word assembly
    always_comb begin
        stat_w        = '0;
        stat_w[14]    = rx_hit;
        stat_w[13:11] = 3'(tx_cnt);
        stat_w[10:8]  = 3'(rx_cnt);
        stat_w[2]     = idle;
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (hit_mctl) begin
            bus_rdata[7:6] = mode_q;
            bus_rdata[1]   = stop_q;
        end else if (hit_fmt) begin
            bus_rdata[13:12] = fmt_q.lvl;
            bus_rdata[9]     = fmt_q.rxie;
            bus_rdata[2]     = fmt_q.msb;
            bus_rdata[1]     = fmt_q.cpha;
            bus_rdata[0]     = fmt_q.cpol;
        end else if (hit_rate) begin
            bus_rdata[8 +: DIV_W]  = div_q;
            bus_rdata[LEN_W-1:0]   = len_q;
        end else if (hit_stat) begin
            bus_rdata = stat_w;
        end else if (hit_data) begin
            bus_rdata[WORD_MAX-1:0] = (rx_cnt == '0) ? '0 : rx_head;
        end
    end

    assign mode   = mode_q;
    assign run_en = (mode_q == OPM_RUN) && !stop_q;
    assign fmt    = fmt_q;
    assign div    = div_q;
    assign len    = len_q;
    assign wide   = (len_q == LEN_W'(16));

endmodule

// File: rtl/spim_top.sv
// SPI master top: register file, transmit and receive queues, serial engine.
// Assumes: one bus access per cycle; a new word starts only when the engine
// is idle and the receive queue has room for the word it will return.
module spim_top
    import spim_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int WORD_MAX   = 16,
    parameter int DIV_W      = 8,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);

    opmode_e             mode_w;
    fmt_t                fmt_w;
    logic [DIV_W-1:0]    div_w;
    logic [7:0]          len_w;
    logic                wide_w;
    logic                run_en;
    logic                tx_push, rx_pop, fifo_clr;
    logic                rx_hit, idle_w;
    logic [CNT_W-1:0]    tx_cnt, rx_cnt;
    logic [WORD_MAX-1:0] tx_head, rx_head, rx_word;
    logic                busy_w, done_w, start_w;

    // Word start: active, not stopped, data waiting, room for the reply
    assign start_w = run_en && (tx_cnt != '0) && (rx_cnt != CNT_W'(FIFO_DEPTH)) && !busy_w;

    spim_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
        .CNT_W(CNT_W), .WORD_MAX(WORD_MAX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .busy(busy_w), .rx_head(rx_head),
        .mode(mode_w), .run_en(run_en), .fmt(fmt_w), .div(div_w), .len(len_w),
        .wide(wide_w), .tx_push(tx_push), .rx_pop(rx_pop), .fifo_clr(fifo_clr),
        .irq(irq), .rx_hit(rx_hit), .idle(idle_w)
    );

    spim_fifo #(.W(WORD_MAX), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(fifo_clr),
        .push(tx_push), .wdata(bus_wdata[WORD_MAX-1:0]),
        .pop(start_w), .rdata(tx_head), .count(tx_cnt)
    );

    spim_fifo #(.W(WORD_MAX), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(fifo_clr),
        .push(done_w), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_head), .count(rx_cnt)
    );

    spim_shifter #(.WORD_MAX(WORD_MAX), .DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start_w), .tx_word(tx_head),
        .wide(wide_w), .msb(fmt_w.msb), .cpol(fmt_w.cpol), .cpha(fmt_w.cpha),
        .div(div_w), .miso(miso), .busy(busy_w), .done(done_w),
        .rx_word(rx_word), .sclk(sclk), .mosi(mosi)
    );

endmodule

// File: rtl/spim_chk.sv
// Property checker for spim_top, attached by the bind at the end of this file.
// Assumes: watched signals are the register outputs and queue counts of the top.
module spim_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3,
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             sclk,
    input logic             busy,
    input logic             run_en,
    input logic [1:0]       mode,
    input logic [5:0]       fmt,
    input logic [DIV_W+7:0] rate,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] rx_cnt,
    input logic             idle
);

    // R2: outside configuration mode the control registers do not move
    assert_cfg_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b01) |=> ($stable(fmt) && $stable(rate)));

    // R3: serial clock rests at the polarity level between words
    assert_sclk_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == fmt[0]));

    // R6: queue counts never pass the depth
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH)));

    // R7: an interrupt needs the enable and at least one received word
    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (fmt[3] && (rx_cnt != '0)));

    // R8: idle means nothing queued and nothing shifting
    assert_idle_meaning_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> ((tx_cnt == '0) && !busy));

    // R9: without run permission an idle shifter stays idle
    assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !busy) |=> !busy);

endmodule

bind spim_top spim_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .sclk(sclk), .busy(busy_w),
    .run_en(run_en), .mode(mode_w), .fmt(fmt_w), .rate({div_w, len_w}),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .idle(idle_w)
);

// File: tb/tb_spim_top.sv
`timescale 1ns/1ps
// Bench for spim_top: directed register cases plus seeded random transfers
// checked against a mode-agnostic slave model.
module tb_spim_top;

    localparam int TCK = 4;
    localparam logic [7:0] A_MCTL = 8'h00, A_FMT = 8'h04, A_RATE = 8'h08,
                           A_STAT = 8'h14, A_DATA = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sclk, mosi;
    logic        miso_r = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    spim_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso_r)
    );

    always #(TCK / 2) clk = ~clk;

    // Slave model: records mosi and advances miso at each sampling edge
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, slv_clr = 1'b0;
    logic resp_bits [0:127];
    logic cap_bits  [0:127];
    int   ns = 0;
    longint t_s [0:1];
    wire  samp_w = sclk ^ cfg_cpol ^ cfg_cpha;

    always @(posedge samp_w or posedge slv_clr) begin
        if (slv_clr) begin
            ns = 0;
            miso_r = resp_bits[0];
        end else begin
            if (ns < 128) cap_bits[ns] = mosi;
            if (ns < 2) t_s[ns] = $time;
            ns = ns + 1;
            miso_r = resp_bits[(ns < 128) ? ns : 0];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic wire_bit(input logic [15:0] w, input int b, input bit msb, input int len);
        return msb ? w[len - 1 - b] : w[b];
    endfunction

    // One full transfer of n words with the given format, checked end to end
    task automatic run_xfer(input bit cpol, input bit cpha, input bit msb,
                            input int len_code, input int div, input int n, input bit hold);
        logic [15:0] txw [4];
        logic [15:0] rsw [4];
        logic [31:0] v;
        int len, eff, bad;
        len = (len_code == 16) ? 16 : 8;
        eff = (div == 0) ? 1 : div;
        reg_write(A_MCTL, 32'h41);
        cfg_cpol = cpol; cfg_cpha = cpha;
        reg_write(A_RATE, (32'(div) << 8) | 32'(len_code));
        reg_write(A_FMT, (32'(n - 1) << 12) | 32'h200 | (32'(msb) << 2) | (32'(cpha) << 1) | 32'(cpol));
        repeat (3) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            txw[k] = 16'($urandom) & ((len == 16) ? 16'hFFFF : 16'h00FF);
            rsw[k] = 16'($urandom) & ((len == 16) ? 16'hFFFF : 16'h00FF);
            for (int b = 0; b < len; b++) resp_bits[k * len + b] = wire_bit(rsw[k], b, msb, len);
        end
        slv_clr = 1'b1; #1 slv_clr = 1'b0;
        for (int k = 0; k < n; k++) reg_write(A_DATA, 32'(txw[k]));
        reg_read(A_STAT, v);
        chk("R6 tx count field", (v >> 11) & 7, 32'(n));
        if (hold) begin
            reg_write(A_MCTL, 32'h82);
            repeat (40) @(negedge clk);
            reg_read(A_STAT, v);
            chk("R9 stop keeps words queued", v, 32'(n) << 11);
            reg_write(A_MCTL, 32'h80);
        end else begin
            reg_write(A_MCTL, 32'h80);
        end
        repeat (3) @(negedge clk);
        reg_read(A_STAT, v);
        chk("R8 idle low while shifting", v & 4, 0);
        chk("R7 no irq before level", 32'(irq), 0);
        for (int k = 0; k < 5000 && irq !== 1'b1; k++) @(negedge clk);
        reg_read(A_STAT, v);
        chk("R7 R8 status at level", v, (32'h1 << 14) | (32'(n) << 8) | 32'h4);
        chk("R7 irq asserted", 32'(irq), 1);
        chk("R11 sampled bit count", 32'(ns), 32'(n * len));
        bad = 0;
        for (int k = 0; k < n; k++)
            for (int b = 0; b < len; b++)
                if (cap_bits[k * len + b] !== wire_bit(txw[k], b, msb, len)) bad++;
        chk("R3 outbound bit stream", 32'(bad), 0);
        chk("R5 sclk period", 32'(t_s[1] - t_s[0]), 32'((eff + 1) * TCK));
        chk("R3 sclk rests at polarity", 32'(sclk), 32'(cpol));
        for (int k = 0; k < n; k++) begin
            reg_read(A_DATA, v);
            chk("R4 received word", v, 32'(rsw[k]));
            if (k == 0) chk("R7 irq drops below level", 32'(irq), 0);
        end
        reg_read(A_STAT, v);
        chk("R6 queues empty after reads", v, 32'h4);
    endtask

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'h5EED_1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        reg_read(A_MCTL, v); chk("R1 mode control", v, 32'h40);
        reg_read(A_FMT, v);  chk("R1 format control", v, 32'h4);
        reg_read(A_RATE, v); chk("R1 rate control", v, 32'h108);
        reg_read(A_STAT, v); chk("R1 status", v, 32'h4);
        chk("R1 irq low", 32'(irq), 0);
        chk("R1 sclk low", 32'(sclk), 0);
        // R2: control writes ignored outside configuration mode
        reg_write(A_MCTL, 32'h80);
        reg_write(A_FMT, 32'h203);
        reg_write(A_RATE, 32'h510);
        reg_read(A_MCTL, v); chk("R2 mode reads active", v, 32'h80);
        reg_read(A_FMT, v);  chk("R2 format frozen", v, 32'h4);
        reg_read(A_RATE, v); chk("R2 rate frozen", v, 32'h108);
        reg_write(A_MCTL, 32'h40);
        reg_write(A_FMT, 32'h203);
        reg_read(A_FMT, v);  chk("R2 format accepted in config", v, 32'h203);
        // R6 R10: overflow drop and clear
        for (int k = 0; k < 5; k++) reg_write(A_DATA, 32'h11 * k);
        reg_read(A_STAT, v); chk("R6 full queue drops fifth word", v, 32'h2000);
        reg_write(A_MCTL, 32'h41);
        reg_read(A_STAT, v); chk("R10 clear empties queues", v, 32'h4);
        // Directed corners
        run_xfer(1'b0, 1'b0, 1'b1, 8, 1, 1, 1'b0);
        run_xfer(1'b1, 1'b1, 1'b0, 16, 255, 1, 1'b0);
        run_xfer(1'b0, 1'b1, 1'b1, 16, 0, 4, 1'b1);
        run_xfer(1'b1, 1'b0, 1'b0, 12, 2, 3, 1'b0);
        // Seeded random mix
        for (int r = 0; r < 24; r++) begin
            int lc;
            lc = (($urandom % 3) == 0) ? 12 : ((($urandom % 2) == 0) ? 8 : 16);
            run_xfer(1'($urandom), 1'($urandom), 1'($urandom), lc,
                     int'($urandom % 6), int'($urandom % 4) + 1, 1'($urandom % 5 == 0));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule